// File: doc/BRIEF.md
# Entropy Stream Health Monitor

This block watches a serial stream of raw entropy bits, one bit per valid strobe, and flags two degenerate patterns. The first is a long run of one value. The second is a long stretch in which every bit is the opposite of the bit before it. Each pattern has its own threshold. Both checks run in parallel on every accepted bit.

Two indications are produced. The live indication is high while a bad pattern is in progress. It drops as soon as an incoming bit breaks the pattern. The latched indication is set when the live indication first goes high, and it stays set until software pulses the clear input. Pulling the enable low empties both streak counters and the live indication. The latched indication is kept while enable is low.

Top module: `entropy_health_mon`

## Requirements
- R1: With RUN_LIMIT=64, the live output is 1 in the cycle after the 65th consecutive accepted bit of equal value, for a run of 0s or of 1s. It is 0 after 64 or fewer such bits.
- R2: With ALT_LIMIT=32, the live output is 1 in the cycle after the 33rd consecutive accepted bit of a strictly alternating stretch, whichever value starts it. It is 0 after 32 or fewer such bits.
- R3: The live output updates in the cycle after each accepted bit and holds its value while no bit is accepted. It returns to 0 after the first accepted bit that breaks the pattern, provided neither count is then over its limit.
- R4: The latched output becomes 1 in the same cycle in which the live output rises from 0 to 1.
- R5: The latched output stays 1 after the live output falls. It falls only in the cycle after a clear pulse.
- R6: If a clear pulse and a new detection fall in the same cycle, the detection wins and the latched output stays 1.
- R7: With enable low, bits are ignored, both streak counts restart, and the live output is 0 in the next cycle. The latched output keeps its value. After enable returns, counting starts from the first new bit.
- R8: Both streak counts saturate and never wrap. A run of 300 equal bits keeps the live output at 1 through its end.
- R9: Cycles in which the valid strobe is low neither extend nor break a run or an alternating stretch.
- R10: After reset both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Monitor enable; when low, counts and live status are cleared |
| bit_vld_i | input | 1 | High when bit_i carries a new entropy bit |
| bit_i | input | 1 | Entropy bit |
| clr_i | input | 1 | One-cycle pulse that clears the latched status |
| live_err_o | output | 1 | Live error: a bad pattern is in progress |
| sticky_err_o | output | 1 | Latched error, held until cleared |

## Verification
A streak counter that is off by one moves the live rising edge one bit early or one bit late. The bench compares the output after every bit of every run length around both limits, so the error is seen at the exact bit where the outputs diverge. A counter that wraps instead of saturating shows up as the live output dropping partway through a very long run. A stale previous-bit register shows up as a wrong restart on the first bit after enable returns. A latched flag that reacts to the clear in the wrong order shows up within one cycle of the clear pulse.

// File: rtl/ehm_pkg.sv
package ehm_pkg;

    // Memory of the last accepted bit
    typedef struct packed {
        logic have;   // at least one bit accepted since enable
        logic prev;   // value of that bit
    } ehm_track_t;

    // Error flag state
    typedef struct packed {
        logic live;
        logic sticky;
    } ehm_flags_t;

    localparam int unsigned EHM_NUM_CTR = 2;
    localparam int unsigned EHM_CTR_RUN = 0;
    localparam int unsigned EHM_CTR_ALT = 1;

endpackage

// File: rtl/ehm_streak_ctr.sv
module ehm_streak_ctr #(
    parameter int unsigned LIMIT = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic step_i,
    input  logic restart_i,
    output logic over_nx_o
);
    localparam int unsigned CAP = LIMIT + 1;
    localparam int unsigned W   = $clog2(CAP + 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } ctr_t;

    ctr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!en_i) begin
            s_d.cnt = '0;
        end else if (step_i) begin
            if (restart_i) begin
                s_d.cnt = W'(1);
            end else if (s_q.cnt != W'(CAP)) begin
                s_d.cnt = s_q.cnt + W'(1);
            end
        end
        over_nx_o = (s_d.cnt == W'(CAP));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/ehm_flag_ctrl.sv
module ehm_flag_ctrl
    import ehm_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hit_nx_i,
    input  logic clr_i,
    output logic live_o,
    output logic sticky_o
);
    ehm_flags_t f_d, f_q;

    always_comb begin
        f_d        = f_q;
        f_d.live   = hit_nx_i;
        // a new detection outranks a clear in the same cycle
        f_d.sticky = (hit_nx_i & ~f_q.live) | (f_q.sticky & ~clr_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign live_o   = f_q.live;
    assign sticky_o = f_q.sticky;

endmodule

// File: rtl/entropy_health_mon.sv
module entropy_health_mon
    import ehm_pkg::*;
#(
    parameter int unsigned RUN_LIMIT = 64,
    parameter int unsigned ALT_LIMIT = 32
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic bit_vld_i,
    input  logic bit_i,
    input  logic clr_i,
    output logic live_err_o,
    output logic sticky_err_o
);
    ehm_track_t trk_d, trk_q;
    logic       same_bit;
    logic       flip_bit;
    logic [EHM_NUM_CTR-1:0] restart;
    logic [EHM_NUM_CTR-1:0] over_nx;
    logic       step;

    always_comb begin
        trk_d = trk_q;
        if (!en_i) begin
            trk_d = '0;
        end else if (bit_vld_i) begin
            trk_d.have = 1'b1;
            trk_d.prev = bit_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign step     = en_i & bit_vld_i;
    assign same_bit = trk_q.have & (bit_i == trk_q.prev);
    assign flip_bit = trk_q.have & (bit_i != trk_q.prev);

    assign restart[EHM_CTR_RUN] = ~same_bit;
    assign restart[EHM_CTR_ALT] = ~flip_bit;

    for (genvar g = 0; g < EHM_NUM_CTR; g++) begin : g_ctr
        localparam int unsigned LIM = (g == EHM_CTR_RUN) ? RUN_LIMIT : ALT_LIMIT;
        ehm_streak_ctr #(
            .LIMIT (LIM)
        ) u_ctr (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .en_i      (en_i),
            .step_i    (step),
            .restart_i (restart[g]),
            .over_nx_o (over_nx[g])
        );
    end

    ehm_flag_ctrl u_flags (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .hit_nx_i (|over_nx),
        .clr_i    (clr_i),
        .live_o   (live_err_o),
        .sticky_o (sticky_err_o)
    );

endmodule

// File: rtl/ehm_checker.sv
module ehm_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic en_i,
    input logic bit_vld_i,
    input logic clr_i,
    input logic live_err_o,
    input logic sticky_err_o
);
    AST_RISE_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(live_err_o) |-> sticky_err_o); // R4

    AST_LATCH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sticky_err_o && !clr_i) |=> sticky_err_o); // R5

    AST_LATCH_FALL_NEEDS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sticky_err_o) |-> $past(clr_i)); // R5

    AST_DISABLE_DROPS_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !live_err_o); // R7

    AST_DISABLE_KEEPS_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i && !clr_i && sticky_err_o) |=> sticky_err_o); // R7

    AST_IDLE_HOLDS_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !bit_vld_i) |=> $stable(live_err_o)); // R3

    AST_RISE_NEEDS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(live_err_o) |-> $past(en_i && bit_vld_i)); // R3

    AST_DETECT_BEATS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(live_err_o) |-> sticky_err_o); // R6
endmodule

bind entropy_health_mon ehm_checker u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .bit_vld_i    (bit_vld_i),
    .clr_i        (clr_i),
    .live_err_o   (live_err_o),
    .sticky_err_o (sticky_err_o)
);

// File: tb/sim_entropy_health_mon.sv
module sim_entropy_health_mon;
    localparam int CLK_PERIOD = 10;
    localparam int RUN_LIM    = 64;
    localparam int ALT_LIM    = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, vld = 1'b0, b = 1'b0, clr = 1'b0;
    logic live, sticky;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // bench model
    bit m_have = 0, m_prev = 0, m_live = 0, m_sticky = 0;
    int m_run = 0, m_alt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    entropy_health_mon #(.RUN_LIMIT(RUN_LIM), .ALT_LIMIT(ALT_LIM)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .bit_vld_i(vld), .bit_i(b),
        .clr_i(clr), .live_err_o(live), .sticky_err_o(sticky));

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one cycle: drive at negedge, check at next negedge
    task automatic step(input bit e, input bit v, input bit bv, input bit c, input string tag);
        bit nlive;
        en = e; vld = v; b = bv; clr = c;
        if (!e) begin
            m_have = 0; m_run = 0; m_alt = 0;
        end else if (v) begin
            if (!m_have) begin m_run = 1; m_alt = 1; end
            else if (bv == m_prev) begin m_run++; m_alt = 1; end
            else begin m_run = 1; m_alt++; end
            m_have = 1; m_prev = bv;
        end
        nlive    = e && ((m_run > RUN_LIM) || (m_alt > ALT_LIM));
        m_sticky = (nlive && !m_live) || (m_sticky && !c);
        m_live   = nlive;
        @(negedge clk);
        check(tag, live, m_live, "live");
        check(tag, sticky, m_sticky, "sticky");
    endtask

    task automatic restart_mon();
        step(0, 0, 0, 1, "R7");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10", live, 1'b0, "live after reset");
        check("R10", sticky, 1'b0, "sticky after reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R1: runs of every length around the limit, both values
        for (int v = 0; v < 2; v++) begin
            for (int len = 1; len <= RUN_LIM + 4; len++) begin
                restart_mon();
                for (int i = 0; i < len; i++) step(1, 1, v[0], 0, "R1");
                check("R1", live, (len > RUN_LIM), "live at end of run");
            end
        end

        // R2: alternating stretches around the limit, both phases
        for (int ph = 0; ph < 2; ph++) begin
            for (int len = 1; len <= ALT_LIM + 4; len++) begin
                restart_mon();
                for (int i = 0; i < len; i++) step(1, 1, ph[0] ^ i[0], 0, "R2");
                check("R2", live, (len > ALT_LIM), "live at end of stretch");
            end
        end

        // R3/R4/R5: break a run, latch stays, idle holds, clear drops
        restart_mon();
        for (int i = 0; i < RUN_LIM + 1; i++) step(1, 1, 1, 0, "R4");
        check("R4", sticky, 1'b1, "latched on rise");
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, "R3");
        step(1, 1, 0, 0, "R3");
        check("R3", live, 1'b0, "live after break");
        for (int i = 0; i < 4; i++) step(1, 0, 1, 0, "R5");
        check("R5", sticky, 1'b1, "latch held");
        step(1, 0, 0, 1, "R5");
        check("R5", sticky, 1'b0, "latch cleared");

        // R6: clear coincides with detection
        restart_mon();
        for (int i = 0; i < RUN_LIM; i++) step(1, 1, 0, 0, "R6");
        step(1, 1, 0, 1, "R6");
        check("R6", sticky, 1'b1, "detection beats clear");

        // R8: very long run stays flagged
        restart_mon();
        for (int i = 0; i < 300; i++) step(1, 1, 1, 0, "R8");
        check("R8", live, 1'b1, "live at end of long run");

        // R9: gaps inside an alternating stretch
        restart_mon();
        for (int i = 0; i < ALT_LIM + 1; i++) begin
            step(1, 1, i[0], 0, "R9");
            step(1, 0, ~i[0], 0, "R9");
        end
        check("R9", live, 1'b1, "alternation through gaps");

        // R7: enable low mid-run ignores bits, keeps latch, restarts count
        step(1, 0, 0, 1, "R7");
        restart_mon();
        for (int i = 0; i < RUN_LIM - 10; i++) step(1, 1, 0, 0, "R7");
        for (int i = 0; i < 5; i++) step(0, 1, 0, 0, "R7");
        check("R7", live, 1'b0, "live with enable low");
        for (int i = 0; i < RUN_LIM; i++) step(1, 1, 0, 0, "R7");
        check("R7", live, 1'b0, "count restarted");
        step(1, 1, 0, 0, "R7");
        check("R7", live, 1'b1, "fresh run over limit");
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, "R7");
        check("R7", sticky, 1'b1, "latch kept while disabled");

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule